// File: doc/BRIEF.md
# Read Prefetch Stop Controller

This block sits in the read path of a bus bridge. When a read request is launched toward the target bus, it works out from the command, the prefetchable flag of the address, the start DWORD address, the cache line size setting and the flow-through flag how far the fetch may run. It then tracks every DWORD the target side accepts and raises a last-DWORD flag on the accept that must be the final one. Depending on the case, the fetch ends at an aligned block edge, on a full read data queue or on the initiator releasing FRAME#.

The fetch limit is computed once, in the cycle the start strobe is seen while idle. A small state machine then runs in one of three run states:
- `ST_COUNT` counts down a fixed number of DWORDs.
- `ST_QUEUE` runs until the queue-full flag accompanies an accept.
- `ST_FLOW` counts down to the next 4 KB edge but also stops early on an accept made while FRAME# is released.

The transitions are:
- `ST_IDLE` to a run state on `start_i`.
- A run state back to itself on any cycle that does not end the fetch.
- A run state back to `ST_IDLE` on the accept that raises `last_o`.

Top module: `rdpf_stop_ctrl`

## Requirements
- R1: `cmd_i` encodes 0 = configuration read, 1 = I/O read, 2 = memory read, 3 = memory read line, 4 = memory read multiple. Codes 0, 1, 5, 6 and 7 fetch exactly one DWORD, whatever the other inputs are, flow-through included.
- R2: A memory read (code 2) with `pref_i` low fetches exactly one DWORD, even in flow-through mode.
- R3: This requirement covers a prefetching memory read (code 2 with `pref_i` high) or a memory read line (code 3), outside flow-through, when `cls_i` is not 1, 2, 4 or 8 (0, 16 and every other value count as 0). The fetch runs to the next 16-DWORD aligned address.
- R4: For the same commands with `cls_i` equal to 1, 2, 4 or 8, the fetch runs to the next address aligned to `cls_i` DWORDs.
- R5: A memory read multiple with `cls_i` equal to 1, 2, 4 or 8, outside flow-through, runs to the second cache line edge after the start address.
- R6: A memory read multiple with any other `cls_i`, outside flow-through, keeps fetching. The last DWORD is the first one accepted while `qfull_i` is high.
- R7: With `flow_i` high, every prefetching command (code 2 with `pref_i` high, 3, or 4) runs to the next 1024-DWORD (4 KB) aligned address. It ends earlier on the first DWORD accepted while `frame_i` is low. `frame_i` is 1 while the initiator holds FRAME# asserted.
- R8: A start address that already lies on the relevant edge fetches the full span up to the following edge, so at least one DWORD is always fetched.
- R9: `fetch_o` rises in the cycle after the start strobe. `last_o` is high only in the same cycle as the final `accept_i`, and `fetch_o` is low in the cycle after it.
- R10: While a fetch is running, `start_i` and changes on `cmd_i`, `pref_i`, `addr_i`, `cls_i` and `flow_i` have no effect on its length. `qfull_i` has no effect outside R6, and `frame_i` has no effect outside R7.
- R11: After reset `fetch_o` and `last_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe, seen only while idle |
| cmd_i | input | 3 | Read command code (see R1) |
| pref_i | input | 1 | Address lies in prefetchable space |
| addr_i | input | ADDR_W | Start DWORD address |
| cls_i | input | CLS_W | Cache line size in DWORDs |
| flow_i | input | 1 | Flow-through mode |
| frame_i | input | 1 | Initiator still holds FRAME# asserted |
| qfull_i | input | 1 | Read data queue full with this accept |
| accept_i | input | 1 | One DWORD accepted this cycle |
| fetch_o | output | 1 | Fetch in progress, keep requesting |
| last_o | output | 1 | Current accepted DWORD is the final one |

## Verification
The bench builds the block with its default parameters: 30-bit DWORD addresses, an 8-bit cache line size, a 16-DWORD block and a 1024-DWORD page. With a 1024-DWORD page, a flow-through run that starts on a page edge reaches its full 4 KB span well inside the cycle budget. The 16-DWORD block also lets all four legal line sizes and the illegal values between them be drawn at random. Random start addresses place starts on and just before every kind of edge. Random accept gaps, junk start strobes and toggling of the inputs that do not apply show that the latched fetch length does not move.

// File: rtl/rdpf_pkg.sv
package rdpf_pkg;

    localparam logic [2:0] CMD_CFG = 3'd0;
    localparam logic [2:0] CMD_IO  = 3'd1;
    localparam logic [2:0] CMD_MR  = 3'd2;
    localparam logic [2:0] CMD_MRL = 3'd3;
    localparam logic [2:0] CMD_MRM = 3'd4;

    typedef enum logic [1:0] {
        MD_COUNT,
        MD_QUEUE,
        MD_FLOW
    } rdpf_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_QUEUE,
        ST_FLOW
    } rdpf_state_e;

endpackage

// File: rtl/rdpf_decode.sv
module rdpf_decode
    import rdpf_pkg::*;
#(
    parameter int CLS_W   = 8,
    parameter int BLK_DW  = 16,
    parameter int PAGE_DW = 1024,
    parameter int CNT_W   = 11
) (
    input  logic [2:0]       cmd,
    input  logic             pref,
    input  logic [CLS_W-1:0] cls,
    input  logic             flow,
    output rdpf_mode_e       mode,
    output logic [CNT_W-1:0] span_sz,
    output logic             two_lines
);

    logic prefetching;
    logic line_ok;

    always_comb begin
        prefetching = (cmd == CMD_MR && pref) || cmd == CMD_MRL || cmd == CMD_MRM;
        // a usable line size is a nonzero power of two below the block size
        line_ok = (cls != '0) && ((cls & (cls - 1'b1)) == '0) && (32'(cls) < BLK_DW);

        mode      = MD_COUNT;
        span_sz   = CNT_W'(1);
        two_lines = 1'b0;
        if (prefetching) begin
            if (flow) begin
                mode    = MD_FLOW;
                span_sz = CNT_W'(PAGE_DW);
            end else if (cmd == CMD_MRM && !line_ok) begin
                mode    = MD_QUEUE;
                span_sz = CNT_W'(BLK_DW);
            end else begin
                mode      = MD_COUNT;
                span_sz   = line_ok ? CNT_W'(cls) : CNT_W'(BLK_DW);
                two_lines = (cmd == CMD_MRM);
            end
        end
    end

endmodule

// File: rtl/rdpf_span.sv
module rdpf_span #(
    parameter int ADDR_W = 30,
    parameter int CNT_W  = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  span_sz,
    input  logic              two_lines,
    output logic [CNT_W-1:0]  remain
);

    logic [CNT_W-1:0] offset;
    logic [CNT_W-1:0] reach;

    always_comb begin
        // span_sz is a power of two, so the offset is a mask of the low bits
        offset = addr[CNT_W-1:0] & (span_sz - 1'b1);
        reach  = two_lines ? (span_sz << 1) : span_sz;
        remain = reach - offset;
    end

endmodule

// File: rtl/rdpf_stop_ctrl.sv
module rdpf_stop_ctrl
    import rdpf_pkg::*;
#(
    parameter int ADDR_W  = 30,
    parameter int CLS_W   = 8,
    parameter int BLK_DW  = 16,
    parameter int PAGE_DW = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        cmd_i,
    input  logic              pref_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CLS_W-1:0]  cls_i,
    input  logic              flow_i,
    input  logic              frame_i,
    input  logic              qfull_i,
    input  logic              accept_i,
    output logic              fetch_o,
    output logic              last_o
);

    localparam int CNT_W = $clog2(PAGE_DW) + 1;

    rdpf_state_e      state_q, state_d;
    logic [CNT_W-1:0] rem_q, rem_d;

    rdpf_mode_e       dec_mode;
    logic [CNT_W-1:0] dec_sz;
    logic             dec_two;
    logic [CNT_W-1:0] span_rem;

    rdpf_decode #(
        .CLS_W  (CLS_W),
        .BLK_DW (BLK_DW),
        .PAGE_DW(PAGE_DW),
        .CNT_W  (CNT_W)
    ) u_decode (
        .cmd      (cmd_i),
        .pref     (pref_i),
        .cls      (cls_i),
        .flow     (flow_i),
        .mode     (dec_mode),
        .span_sz  (dec_sz),
        .two_lines(dec_two)
    );

    rdpf_span #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_span (
        .addr     (addr_i),
        .span_sz  (dec_sz),
        .two_lines(dec_two),
        .remain   (span_rem)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    // outputs
    always_comb begin
        fetch_o = (state_q != ST_IDLE);
        last_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  last_o = 1'b0;
            ST_COUNT: last_o = accept_i && (rem_q == CNT_W'(1));
            ST_QUEUE: last_o = accept_i && qfull_i;
            ST_FLOW:  last_o = accept_i && ((rem_q == CNT_W'(1)) || !frame_i);
            default:  last_o = 1'b0;
        endcase
    end

    // transitions
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    rem_d = span_rem;
                    unique case (dec_mode)
                        MD_COUNT: state_d = ST_COUNT;
                        MD_QUEUE: state_d = ST_QUEUE;
                        MD_FLOW:  state_d = ST_FLOW;
                        default:  state_d = ST_COUNT;
                    endcase
                end
            end
            ST_COUNT, ST_FLOW: begin
                if (last_o) begin
                    state_d = ST_IDLE;
                end else if (accept_i) begin
                    rem_d = rem_q - 1'b1;
                end
            end
            ST_QUEUE: begin
                if (last_o) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/rdpf_stop_ctrl_chk.sv
module rdpf_stop_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [2:0] cmd_i,
    input logic       accept_i,
    input logic       fetch_o,
    input logic       last_o
);

    assert_last_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> accept_i);

    assert_last_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> fetch_o);

    assert_idle_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !fetch_o);

    assert_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !fetch_o) |=> fetch_o);

    assert_hold_until_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_o && !last_o) |=> fetch_o);

    assert_single_dword_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !fetch_o && (cmd_i == 3'd0 || cmd_i == 3'd1)) |=> (!accept_i || last_o));

    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_o |-> !last_o);

endmodule

bind rdpf_stop_ctrl rdpf_stop_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cmd_i   (cmd_i),
    .accept_i(accept_i),
    .fetch_o (fetch_o),
    .last_o  (last_o)
);

// File: tb/rdpf_stop_ctrl_bench.sv
module rdpf_stop_ctrl_bench;

    localparam int ADDR_W  = 30;
    localparam int CLS_W   = 8;
    localparam int BLK_DW  = 16;
    localparam int PAGE_DW = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [2:0]        cmd_i = '0;
    logic              pref_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [CLS_W-1:0]  cls_i = '0;
    logic              flow_i = 1'b0;
    logic              frame_i = 1'b1;
    logic              qfull_i = 1'b0;
    logic              accept_i = 1'b0;
    logic              fetch_o;
    logic              last_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rdpf_stop_ctrl #(
        .ADDR_W (ADDR_W),
        .CLS_W  (CLS_W),
        .BLK_DW (BLK_DW),
        .PAGE_DW(PAGE_DW)
    ) u_rdpf_stop_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .cmd_i   (cmd_i),
        .pref_i  (pref_i),
        .addr_i  (addr_i),
        .cls_i   (cls_i),
        .flow_i  (flow_i),
        .frame_i (frame_i),
        .qfull_i (qfull_i),
        .accept_i(accept_i),
        .fetch_o (fetch_o),
        .last_o  (last_o)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // kind: 0 fixed count, 1 until queue full, 2 flow-through
    function automatic int ref_len(input logic [2:0] c, input logic p, input logic [ADDR_W-1:0] a,
                                   input logic [CLS_W-1:0] cl, input logic fl, output int kind);
        int  base;
        int  n;
        bit  lin;
        kind = 0;
        if (!((c == 3'd2 && p) || c == 3'd3 || c == 3'd4)) return 1;
        lin = (cl == 8'd1) || (cl == 8'd2) || (cl == 8'd4) || (cl == 8'd8);
        if (fl) begin
            kind = 2;
            return PAGE_DW - (int'(a[9:0]) % PAGE_DW);
        end
        if (c == 3'd4 && !lin) begin
            kind = 1;
            return 0;
        end
        base = lin ? int'(cl) : BLK_DW;
        n = base - (int'(a[9:0]) % base);
        if (c == 3'd4) n += base;
        return n;
    endfunction

    task automatic run_one(input logic [2:0] c, input logic p, input logic [ADDR_W-1:0] a,
                           input logic [CLS_W-1:0] cl, input logic fl, input int fdrop,
                           input int qf, input string force_tag);
        int    kind;
        int    n;
        int    got;
        bit    done;
        bit    acc;
        bit    exp_last;
        string tag;
        n = ref_len(c, p, a, cl, fl, kind);
        if (kind == 1) n = qf;
        if (kind == 2 && fdrop < n) n = fdrop;
        if (!(c == 3'd2 || c == 3'd3 || c == 3'd4)) tag = "R1";
        else if (c == 3'd2 && !p) tag = "R2";
        else if (kind == 2) tag = "R7";
        else if (kind == 1) tag = "R6";
        else if (c == 3'd4) tag = "R5";
        else if ((cl == 8'd1) || (cl == 8'd2) || (cl == 8'd4) || (cl == 8'd8)) tag = "R4";
        else tag = "R3";
        if (force_tag != "") tag = force_tag;

        @(negedge clk);
        start_i = 1'b1; cmd_i = c; pref_i = p; addr_i = a; cls_i = cl; flow_i = fl;
        accept_i = 1'b0; frame_i = 1'b1; qfull_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        chk(fetch_o == 1'b1, "R9", "fetch after start", int'(fetch_o), 1);
        got = 0;
        done = 0;
        while (!done && got < n + 5) begin
            acc = ($urandom_range(3) != 0);
            exp_last = acc && (got + 1 == n);
            accept_i = acc;
            frame_i = (kind == 2) ? (got + 1 < fdrop) : 1'($urandom_range(1));
            qfull_i = (kind == 1) ? (got + 1 >= qf) : 1'($urandom_range(1));
            // R10: junk launch and input churn while busy
            if (!exp_last && $urandom_range(3) == 0) begin
                start_i = 1'b1;
                cmd_i   = 3'($urandom);
                pref_i  = 1'($urandom);
                addr_i  = ADDR_W'($urandom);
                cls_i   = CLS_W'($urandom);
                flow_i  = 1'($urandom);
            end else begin
                start_i = 1'b0;
            end
            #1;
            chk(last_o == exp_last, tag, "last flag", int'(last_o), int'(exp_last));
            if (acc) got++;
            if (exp_last || last_o) done = 1;
            @(negedge clk);
        end
        if (!done) chk(1'b0, tag, "fetch never ended, dwords", got, n);
        accept_i = 1'b0;
        start_i  = 1'b0;
        #1;
        chk(fetch_o == 1'b0, "R9", "idle after last", int'(fetch_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", "cycles", 150000, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk(fetch_o == 1'b0, "R11", "fetch in reset", int'(fetch_o), 0);
        chk(last_o == 1'b0, "R11", "last in reset", int'(last_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(fetch_o == 1'b0, "R11", "fetch after reset", int'(fetch_o), 0);

        // directed corners
        run_one(3'd0, 1'b1, 30'd7,    8'd0,  1'b1, 99, 99, "R1");
        run_one(3'd1, 1'b1, 30'd16,   8'd4,  1'b0, 99, 99, "R1");
        run_one(3'd6, 1'b1, 30'd3,    8'd8,  1'b1, 99, 99, "R1");
        run_one(3'd2, 1'b0, 30'd5,    8'd0,  1'b1, 99, 99, "R2");
        run_one(3'd3, 1'b0, 30'd5,    8'd0,  1'b0, 99, 99, "R3");
        run_one(3'd2, 1'b1, 30'd5,    8'd3,  1'b0, 99, 99, "R3");
        run_one(3'd3, 1'b1, 30'd15,   8'd16, 1'b0, 99, 99, "R3");
        run_one(3'd3, 1'b0, 30'd6,    8'd4,  1'b0, 99, 99, "R4");
        run_one(3'd2, 1'b1, 30'd32,   8'd0,  1'b0, 99, 99, "R8");
        run_one(3'd3, 1'b1, 30'd9,    8'd1,  1'b0, 99, 99, "R8");
        run_one(3'd4, 1'b0, 30'd8,    8'd4,  1'b0, 99, 99, "R8");
        run_one(3'd4, 1'b1, 30'd3,    8'd8,  1'b0, 99, 99, "R5");
        run_one(3'd4, 1'b0, 30'd1,    8'd0,  1'b0, 99, 40, "R6");
        run_one(3'd4, 1'b0, 30'd1,    8'd5,  1'b0, 99, 1,  "R6");
        run_one(3'd2, 1'b1, 30'd1020, 8'd0,  1'b1, 100, 99, "R7");
        run_one(3'd4, 1'b0, 30'd100,  8'd2,  1'b1, 1,  99, "R7");
        run_one(3'd3, 1'b0, 30'd2048, 8'd0,  1'b1, 2000, 99, "R8");

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0]        rc;
            logic [ADDR_W-1:0] ra;
            logic [CLS_W-1:0]  rl;
            case ($urandom_range(5))
                0: rl = 8'd0;
                1: rl = 8'd16;
                2: rl = CLS_W'($urandom);
                default: rl = CLS_W'(1 << $urandom_range(3));
            endcase
            rc = ($urandom_range(4) == 0) ? 3'($urandom) : 3'(2 + $urandom_range(2));
            ra = ADDR_W'($urandom);
            if ($urandom_range(3) == 0) ra[9:0] = 10'(PAGE_DW - 1 - $urandom_range(7));
            run_one(rc, 1'($urandom), ra, rl, ($urandom_range(3) == 0),
                    1 + $urandom_range(47), 1 + $urandom_range(63), "");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule